// File: doc/BRIEF.md
# Single-Level Page Table Walker

This block refills a translation on a miss by fetching one page table entry from memory. The requester presents a virtual address, a page-table base value and two optional update flags: mark referenced and mark dirty. The table is a flat array of 32-bit entries indexed by virtual page number. The walker computes the entry's address and issues one read on a simple request/response memory port. It then decodes the returned word.

A resident page produces a physical address plus the entry's status flags. The physical address is the entry's frame number joined to the untranslated 12-bit page offset. A non-resident page produces a fault indication and nothing else. The walker can also be asked to set the referenced or dirty flag. If it is asked to set a flag that is still clear in the stored entry, it writes the updated entry back to the same address before reporting. A parameter removes the write-back path entirely. Only one walk runs at a time, and while `busy` is high new requests are dropped.

Entry layout used throughout:
- bit 0 = present
- bit 1 = referenced
- bit 2 = dirty
- bit 3 = writable
- bit 4 = user-accessible
- bits 31:12 = physical frame number

Top module: `pt_walker`

## Requirements
- R1: After reset `busy`, `done`, `fault` and `mem_req` are all low.
- R2: A walk request accepted while idle raises `busy` on the next cycle. In that same cycle it issues a read (`mem_req`=1, `mem_we`=0) at address base + 4 × VPN, where VPN is the virtual address bits above bit 11.
- R3: At most one memory access is outstanding. Each access asserts `mem_req` for exactly one cycle, and no further access begins before `mem_rvalid` answers it.
- R4: For a returned entry with bit 0 set, `done` pulses one cycle after the response. No write-back takes place in that case. With the pulse, `done_paddr` = {entry[31:12], vaddr[11:0]} and `fault` is low.
- R5: With `done`, the flags are reported from the final entry: `done_ref` from bit 1, `done_dirty` from bit 2, `done_wr` from bit 3 and `done_user` from bit 4.
- R6: For a returned entry with bit 0 clear, `done` and `fault` pulse together one cycle after the response, and no write is issued.
- R7: A resident entry may have bit 1 clear while mark-referenced was requested, or bit 2 clear while mark-dirty was requested. In either case the cycle after the response issues a write (`mem_we`=1) to the same address. Its data equals the entry with the requested bits set and all other bits unchanged. `done` pulses one cycle after that write's `mem_rvalid` acknowledgement, and the reported flags show the set bits.
- R8: When every requested flag is already set in the entry, no write is issued.
- R9: A `walk_valid` pulse while `busy` is high has no effect. The running walk completes with its own address, and no second walk follows.
- R10: `done` lasts one cycle, and `busy` is low in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| walk_valid | input | 1 | Start a walk (sampled when idle) |
| walk_vaddr | input | VA_W | Virtual address that missed |
| walk_mark_ref | input | 1 | Request referenced flag be set |
| walk_mark_dirty | input | 1 | Request dirty flag be set |
| pt_base | input | PA_W | Physical base address of the page table |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Page not present (valid with done) |
| done_paddr | output | PA_W | Translated physical address |
| done_ref | output | 1 | Referenced flag of final entry |
| done_dirty | output | 1 | Dirty flag of final entry |
| done_wr | output | 1 | Writable flag |
| done_user | output | 1 | User-access flag |
| mem_req | output | 1 | Memory access strobe (one cycle) |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | PA_W | Access address |
| mem_wdata | output | 32 | Write data |
| mem_rvalid | input | 1 | Read data valid / write acknowledge |
| mem_rdata | input | 32 | Read data |

## Verification
The hardest situation to reach from the ports is a second request arriving while a walk is stalled on memory. It matters because a careless controller would relatch the address or start an extra read. The bench holds the response off for several cycles and pulses `walk_valid` with a different address during that wait. It then confirms that the completed walk reports the first address and that the port stays quiet afterwards. The write-back path is reached by choosing entries whose referenced or dirty flag is clear while the matching mark request is set. The skip case is reached by choosing entries whose requested flags are already set.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
   localparam int PTE_W      = 32;
   localparam int PAGE_OFF_W = 12;
   localparam int BIT_PRES   = 0;
   localparam int BIT_REF    = 1;
   localparam int BIT_DIRTY  = 2;
   localparam int BIT_WR     = 3;
   localparam int BIT_USER   = 4;

   typedef enum logic [2:0] {
      ST_IDLE    = 3'd0,
      ST_REQ     = 3'd1,
      ST_WAIT    = 3'd2,
      ST_WB      = 3'd3,
      ST_WB_WAIT = 3'd4,
      ST_DONE    = 3'd5
   } walk_state_t;
endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
   parameter int VPN_W = 20,
   parameter int PA_W  = 32
) (
   input  logic [PA_W-1:0]  base,
   input  logic [VPN_W-1:0] vpn,
   output logic [PA_W-1:0]  entry_addr
);
   localparam int IDX_W = VPN_W + 2;
   logic [PA_W-1:0] idx_ext;

   always_comb begin
      idx_ext = '0;
      idx_ext[IDX_W-1:0] = {vpn, 2'b00};
      entry_addr = base + idx_ext;
   end
endmodule

// File: rtl/ptw_pte_decode.sv
module ptw_pte_decode
   import ptw_pkg::*;
(
   input  logic [PTE_W-1:0] pte,
   input  logic             mark_ref,
   input  logic             mark_dirty,
   output logic             present,
   output logic             needs_wb,
   output logic [PTE_W-1:0] pte_upd
);
   always_comb begin
      pte_upd = pte;
      pte_upd[BIT_REF]   = pte[BIT_REF] | mark_ref;
      pte_upd[BIT_DIRTY] = pte[BIT_DIRTY] | mark_dirty;
      present  = pte[BIT_PRES];
      needs_wb = present && (pte_upd != pte);
   end
endmodule

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
   import ptw_pkg::*;
#(
   parameter bit WB_EN = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        walk_valid,
   input  logic        mem_rvalid,
   input  logic        entry_present,
   input  logic        entry_wb,
   output walk_state_t state,
   output logic        accept,
   output logic        capture
);
   walk_state_t nxt;
   logic        go_wb;

   generate
      if (WB_EN) begin : g_wb
         assign go_wb = entry_present && entry_wb;
      end else begin : g_nowb
         assign go_wb = 1'b0;
      end
   endgenerate

   assign accept  = (state == ST_IDLE) && walk_valid;
   assign capture = (state == ST_WAIT) && mem_rvalid;

   always_comb begin
      nxt = state;
      unique case (state)
         ST_IDLE:    if (walk_valid) nxt = ST_REQ;
         ST_REQ:     nxt = ST_WAIT;
         ST_WAIT:    if (mem_rvalid) nxt = go_wb ? ST_WB : ST_DONE;
         ST_WB:      nxt = ST_WB_WAIT;
         ST_WB_WAIT: if (mem_rvalid) nxt = ST_DONE;
         ST_DONE:    nxt = ST_IDLE;
         default:    nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= ST_IDLE;
      else        state <= nxt;
   end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
   import ptw_pkg::*;
#(
   parameter int VA_W  = 32,
   parameter int PA_W  = 32,
   parameter bit WB_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              walk_valid,
   input  logic [VA_W-1:0]   walk_vaddr,
   input  logic              walk_mark_ref,
   input  logic              walk_mark_dirty,
   input  logic [PA_W-1:0]   pt_base,
   output logic              busy,
   output logic              done,
   output logic              fault,
   output logic [PA_W-1:0]   done_paddr,
   output logic              done_ref,
   output logic              done_dirty,
   output logic              done_wr,
   output logic              done_user,
   output logic              mem_req,
   output logic              mem_we,
   output logic [PA_W-1:0]   mem_addr,
   output logic [PTE_W-1:0]  mem_wdata,
   input  logic              mem_rvalid,
   input  logic [PTE_W-1:0]  mem_rdata
);
   localparam int VPN_W = VA_W - PAGE_OFF_W;
   localparam int PPN_W = PA_W - PAGE_OFF_W;

   initial begin
      assert (VA_W > PAGE_OFF_W) else $error("VA_W too small");
      assert (PA_W > PAGE_OFF_W && PA_W <= PTE_W) else $error("PA_W out of range");
      assert (VPN_W + 2 <= PA_W) else $error("table index exceeds PA_W");
   end

   walk_state_t      state;
   logic             accept, capture;
   logic [VA_W-1:0]  vaddr_q;
   logic [PA_W-1:0]  base_q;
   logic             mref_q, mdirty_q;
   logic [PTE_W-1:0] entry_q, pte_upd;
   logic             present, needs_wb;

   ptw_ctrl #(.WB_EN(WB_EN)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .walk_valid(walk_valid),
      .mem_rvalid(mem_rvalid), .entry_present(present), .entry_wb(needs_wb),
      .state(state), .accept(accept), .capture(capture)
   );

   ptw_addr_gen #(.VPN_W(VPN_W), .PA_W(PA_W)) u_addr (
      .base(base_q), .vpn(vaddr_q[VA_W-1:PAGE_OFF_W]), .entry_addr(mem_addr)
   );

   ptw_pte_decode u_dec (
      .pte(mem_rdata), .mark_ref(mref_q), .mark_dirty(mdirty_q),
      .present(present), .needs_wb(needs_wb), .pte_upd(pte_upd)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vaddr_q  <= '0;
         base_q   <= '0;
         mref_q   <= 1'b0;
         mdirty_q <= 1'b0;
         entry_q  <= '0;
      end else begin
         if (accept) begin
            vaddr_q  <= walk_vaddr;
            base_q   <= pt_base;
            mref_q   <= walk_mark_ref;
            mdirty_q <= walk_mark_dirty;
         end
         if (capture) entry_q <= (WB_EN && present) ? pte_upd : mem_rdata;
      end
   end

   assign busy       = (state != ST_IDLE);
   assign done       = (state == ST_DONE);
   assign fault      = done && !entry_q[BIT_PRES];
   assign mem_req    = (state == ST_REQ) || (state == ST_WB);
   assign mem_we     = (state == ST_WB);
   assign mem_wdata  = entry_q;
   assign done_paddr = {entry_q[PAGE_OFF_W +: PPN_W], vaddr_q[PAGE_OFF_W-1:0]};
   assign done_ref   = entry_q[BIT_REF];
   assign done_dirty = entry_q[BIT_DIRTY];
   assign done_wr    = entry_q[BIT_WR];
   assign done_user  = entry_q[BIT_USER];
endmodule

// File: rtl/ptw_checker.sv
module ptw_checker #(
   parameter int PA_W = 32
) (
   input logic            clk,
   input logic            rst_n,
   input logic            walk_valid,
   input logic            busy,
   input logic            done,
   input logic            fault,
   input logic            mem_req,
   input logic            mem_we,
   input logic [PA_W-1:0] mem_addr,
   input logic [31:0]     mem_wdata
);
   // R2
   start_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (walk_valid && !busy) |=> (busy && mem_req && !mem_we));
   // R3
   single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |=> !mem_req);
   // R3
   req_in_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> busy);
   // R6
   fault_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fault |-> done);
   // R7
   wb_present_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |-> (mem_wdata[0] && (mem_wdata[1] || mem_wdata[2])));
   // R9
   addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(mem_addr));
   // R10
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!done && !busy));
endmodule

bind pt_walker ptw_checker #(.PA_W(PA_W)) u_ptw_chk (
   .clk(clk), .rst_n(rst_n), .walk_valid(walk_valid), .busy(busy),
   .done(done), .fault(fault), .mem_req(mem_req), .mem_we(mem_we),
   .mem_addr(mem_addr), .mem_wdata(mem_wdata)
);

// File: tb/pt_walker_test.sv
module pt_walker_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        walk_valid = 1'b0;
   logic [31:0] walk_vaddr = '0;
   logic        walk_mark_ref = 1'b0, walk_mark_dirty = 1'b0;
   logic [31:0] pt_base = '0;
   logic        busy, done, fault, done_ref, done_dirty, done_wr, done_user;
   logic [31:0] done_paddr;
   logic        mem_req, mem_we;
   logic [31:0] mem_addr, mem_wdata;
   logic        mem_rvalid = 1'b0;
   logic [31:0] mem_rdata = '0;

   int total = 0, bad = 0, cycles = 0;

   always #10 clk = ~clk;

   pt_walker uut (
      .clk(clk), .rst_n(rst_n), .walk_valid(walk_valid), .walk_vaddr(walk_vaddr),
      .walk_mark_ref(walk_mark_ref), .walk_mark_dirty(walk_mark_dirty),
      .pt_base(pt_base), .busy(busy), .done(done), .fault(fault),
      .done_paddr(done_paddr), .done_ref(done_ref), .done_dirty(done_dirty),
      .done_wr(done_wr), .done_user(done_user), .mem_req(mem_req), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid),
      .mem_rdata(mem_rdata)
   );

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         total++; bad++;
         $display("FAIL watchdog: run hung, act=%0d exp<100000", cycles);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   // Runs one walk; expected values derived from the entry layout in the requirements.
   task automatic run_walk(input logic [31:0] va, input logic [31:0] base, input bit sr, input bit sd,
                           input logic [31:0] pte, input int lat, input bit intrude);
      logic [31:0] addr_x, upd;
      bit          pres, wb;
      addr_x = base + {va[31:12], 2'b00};
      pres   = pte[0];
      upd    = pte | {29'd0, sd, sr, 1'b0};
      wb     = pres && (upd != pte);
      if (!pres) upd = pte;
      @(negedge clk);
      walk_valid = 1'b1; walk_vaddr = va; pt_base = base;
      walk_mark_ref = sr; walk_mark_dirty = sd;
      @(negedge clk);
      walk_valid = 1'b0;
      chk(busy && mem_req && !mem_we, "R2 read strobe", {busy, mem_req, mem_we}, 3'b110);
      chk(mem_addr == addr_x, "R2 read addr", mem_addr, addr_x);
      @(negedge clk);
      chk(!mem_req, "R3 no access while waiting", mem_req, 0);
      for (int i = 0; i < lat; i++) begin
         if (intrude && i == 0) begin
            walk_valid = 1'b1; walk_vaddr = va ^ 32'h5555_5000;
         end
         @(negedge clk);
         walk_valid = 1'b0;
         chk(!mem_req && busy, "R3 R9 still waiting", {mem_req, busy}, 2'b01);
      end
      mem_rvalid = 1'b1; mem_rdata = pte;
      @(negedge clk);
      mem_rvalid = 1'b0; mem_rdata = '0;
      if (wb) begin
         chk(mem_req && mem_we && !done, "R7 write strobe", {mem_req, mem_we, done}, 3'b110);
         chk(mem_addr == addr_x, "R7 write addr", mem_addr, addr_x);
         chk(mem_wdata == upd, "R7 write data", mem_wdata, upd);
         @(negedge clk);
         chk(!mem_req && !done, "R3 wait for ack", {mem_req, done}, 0);
         mem_rvalid = 1'b1;
         @(negedge clk);
         mem_rvalid = 1'b0;
      end else begin
         chk(!(mem_req && mem_we), "R8 R6 no write", {mem_req, mem_we}, 0);
      end
      chk(done, "R4 R6 done pulse", done, 1);
      if (pres) begin
         chk(!fault, "R4 no fault", fault, 0);
         chk(done_paddr == {pte[31:12], va[11:0]}, "R4 R9 paddr", done_paddr, {pte[31:12], va[11:0]});
         chk({done_user, done_wr, done_dirty, done_ref} == upd[4:1], "R5 flags",
             {done_user, done_wr, done_dirty, done_ref}, upd[4:1]);
      end else begin
         chk(fault, "R6 fault", fault, 1);
      end
      @(negedge clk);
      chk(!done && !busy, "R10 pulse ends", {done, busy}, 0);
      @(negedge clk);
      chk(!busy && !mem_req, "R9 no second walk", {busy, mem_req}, 0);
   endtask

   task automatic t_reset();
      chk(!busy && !done && !fault && !mem_req, "R1 reset state", {busy, done, fault, mem_req}, 0);
   endtask

   task automatic t_hit();
      run_walk(32'h1234_5ABC, 32'h0010_0000, 1'b0, 1'b0, 32'hCAFE_B01B, 3, 1'b0);
   endtask

   task automatic t_fault();
      run_walk(32'h0000_7123, 32'h0020_0000, 1'b1, 1'b1, 32'hFFFF_F01E, 1, 1'b0);
   endtask

   task automatic t_wb_ref();
      run_walk(32'hABCD_E004, 32'h0030_0000, 1'b1, 1'b0, 32'h000A_B009, 0, 1'b0);
   endtask

   task automatic t_wb_dirty();
      run_walk(32'h0040_1FFF, 32'h0000_1000, 1'b0, 1'b1, 32'h0007_7013, 2, 1'b0);
   endtask

   task automatic t_no_wb();
      run_walk(32'hFFFF_F000, 32'h0100_0000, 1'b1, 1'b1, 32'h0005_5007, 1, 1'b0);
   endtask

   task automatic t_intrude();
      run_walk(32'h0BAD_0123, 32'h0050_0000, 1'b0, 1'b0, 32'h1357_9003, 4, 1'b1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_hit();
      t_fault();
      t_wb_ref();
      t_wb_dirty();
      t_no_wb();
      t_intrude();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule